// File: doc/BRIEF.md
# DMA Channel Programming Register Front End

This block is the software-facing side of a multi-channel DMA controller. A processor reaches it over a narrow 8-bit I/O register bus. Through that bus it loads, for every channel, a 26-bit requester address, a 26-bit target address and a 24-bit byte count. The block drives these values, a per-channel mask vector and a completion interrupt into the transfer engine. The transfer engine itself is not part of this block.

The two low bytes of each wide value share one bus address. A single byte-select flip-flop, common to all channels, picks which of the two bytes is accessed, and it flips after every read or write of a shared address. The higher bytes have addresses of their own. Four write-only command addresses act on the write alone, whatever the data: they return the byte selector to the low byte, restore the whole block to its defaults, enable every channel at once, or drop the completion interrupt.

Top module: `dma_regif_top`

## Requirements
- R1: After a synchronous active-low reset, all address and count values are zero, every mask bit is 1, the interrupt is 0 and the byte selector is 0.
- R2: Offsets 0 (requester), 3 (target) and 6 (count) of a channel are shared addresses. Selector 0 accesses bits 7:0 and selector 1 accesses bits 15:8. Each read (`io_rd`) or write (`io_wr`) of a shared address flips the selector on the clock edge that ends the access.
- R3: Offsets 1, 4 and 7 hold bits 23:16 of the requester address, the target address and the count. Offsets 2 and 5 hold address bits 25:24, taken from data bits 1:0. On a read, the upper six data bits of offsets 2 and 5 return 0. None of these offsets moves the selector, and none changes any other byte.
- R4: `io_rdata` is combinational from `io_addr` alone. It gives the selected byte of a channel register, the mask vector zero-extended at the mask address, and 0 at command and unused addresses.
- R5: A write to command address 0x20, with any data, sets the selector to 0.
- R6: A write to command address 0x21, with any data, restores every R1 default on the next edge, even if a transfer-complete pulse arrives in the same cycle.
- R7: A write to address 0x24 loads the mask vector from data bits 3:0. Bit n is channel n, and 1 means the channel is disabled.
- R8: A write to command address 0x22, with any data, clears all mask bits in one cycle.
- R9: A `tc_pulse_i` cycle sets `tc_irq_o` on the next edge. The interrupt stays set until it is cleared.
- R10: A write to command address 0x23, with any data, clears `tc_irq_o`. If `tc_pulse_i` is high in the same cycle, the interrupt stays set.
- R11: Channel c owns addresses c*8 to c*8+7. The four channels take 0x00 to 0x1F, so a write to one channel leaves the other channels unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 6 | Register bus address |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational |
| tc_pulse_i | input | 1 | Transfer-complete event from the datapath |
| req_addr_o | output | 104 | Requester addresses, channel c at bits c*26 +: 26 |
| tgt_addr_o | output | 104 | Target addresses, channel c at bits c*26 +: 26 |
| byte_cnt_o | output | 96 | Byte counts, channel c at bits c*24 +: 24 |
| ch_mask_o | output | 4 | Channel disable mask |
| tc_irq_o | output | 1 | Completion interrupt |

## Verification
The hardest state to reach is a byte selector that is out of step with the programmer's intent. The selector cannot be seen directly, so the stimulus leaves it at 1 on purpose: it uses single shared writes, plain reads that flip it, and accesses to the dedicated bytes in between, which must not move it. It then shows where the next shared write lands, both before and after a selector-clear command. The bench also drives the transfer-complete pulse in the same cycle as the interrupt-clear command and in the same cycle as the controller-clear command, so both priority orders are exercised.

// File: rtl/dma_regif_pkg.sv
// Package: shared offsets and sizes for the DMA register front end.
// Assumes each channel occupies eight consecutive byte addresses.
package dma_regif_pkg;
    localparam int BYTE_W    = 8;
    localparam int CH_SLOTS  = 8;
    localparam int FIELD_PAD = 32;

    typedef enum logic [2:0] {
        OFF_REQ_LO = 3'd0,
        OFF_REQ_B2 = 3'd1,
        OFF_REQ_B3 = 3'd2,
        OFF_TGT_LO = 3'd3,
        OFF_TGT_B2 = 3'd4,
        OFF_TGT_B3 = 3'd5,
        OFF_CNT_LO = 3'd6,
        OFF_CNT_B2 = 3'd7
    } reg_off_e;

    // Command slots that follow the channel block
    localparam int CMD_CLR_PTR  = 0;
    localparam int CMD_CLR_ALL  = 1;
    localparam int CMD_CLR_MASK = 2;
    localparam int CMD_CLR_TC   = 3;
    localparam int CMD_MASK_REG = 4;
endpackage

// File: rtl/dma_cmd_decode.sv
// Address decoder: turns a bus address into a channel select and an offset,
// and turns writes to command slots into one-cycle strobes.
// Assumes at most one access per cycle and an address space of exactly IO_AW bits.
module dma_cmd_decode
    import dma_regif_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int IO_AW  = 6
) (
    input  logic [IO_AW-1:0]  io_addr,
    input  logic              io_wr,
    output logic [NUM_CH-1:0] chan_sel,
    output reg_off_e          off,
    output logic              shared_hit,
    output logic              mask_hit,
    output logic              clr_ptr,
    output logic              clr_all,
    output logic              clr_mask,
    output logic              clr_tc,
    output logic              mask_we
);
    localparam int CMD_BASE = NUM_CH * CH_SLOTS;

    logic in_chan;

    // Channel select and offset split
    always_comb begin
        in_chan = (32'(io_addr) < CMD_BASE);
        off     = reg_off_e'(io_addr[2:0]);
        for (int c = 0; c < NUM_CH; c++) begin
            chan_sel[c] = in_chan && (32'(io_addr[IO_AW-1:3]) == c);
        end
        shared_hit = in_chan && (off == OFF_REQ_LO || off == OFF_TGT_LO || off == OFF_CNT_LO);
    end

    // Command strobes, active only on writes
    always_comb begin
        mask_hit = (32'(io_addr) == CMD_BASE + CMD_MASK_REG);
        clr_ptr  = io_wr && (32'(io_addr) == CMD_BASE + CMD_CLR_PTR);
        clr_all  = io_wr && (32'(io_addr) == CMD_BASE + CMD_CLR_ALL);
        clr_mask = io_wr && (32'(io_addr) == CMD_BASE + CMD_CLR_MASK);
        clr_tc   = io_wr && (32'(io_addr) == CMD_BASE + CMD_CLR_TC);
        mask_we  = io_wr && mask_hit;
    end
endmodule

// File: rtl/dma_byte_ptr.sv
// Byte-select flip-flop shared by every channel's split registers.
// Assumes a clear and a shared access never fall in the same cycle.
module dma_byte_ptr (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_all,
    input  logic clr_ptr,
    input  logic access,
    output logic ptr
);
    // Clear to low byte, otherwise flip on each shared access
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all || clr_ptr) ptr <= 1'b0;
        else if (access)                  ptr <= ~ptr;
    end

    p_ptr_flip_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (access && !clr_all && !clr_ptr) |=> (ptr != $past(ptr)));
    p_ptr_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_ptr |=> !ptr);
endmodule

// File: rtl/dma_chan_regs.sv
// One channel's requester address, target address and byte count,
// written and read one byte at a time.
// Assumes ADDR_W is 25..32 and CNT_W is 17..24.
module dma_chan_regs
    import dma_regif_pkg::*;
#(
    parameter int ADDR_W = 26,
    parameter int CNT_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_all,
    input  logic              we,
    input  reg_off_e          off,
    input  logic              ptr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [ADDR_W-1:0] req_q,
    output logic [ADDR_W-1:0] tgt_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [BYTE_W-1:0] rbyte
);
    logic [1:0]           bidx;
    logic [FIELD_PAD-1:0] rfield;
    logic [FIELD_PAD-1:0] wfield;

    // Byte lane chosen by the offset, or by the pointer on shared offsets
    always_comb begin
        unique case (off)
            OFF_REQ_LO, OFF_TGT_LO, OFF_CNT_LO: bidx = {1'b0, ptr};
            OFF_REQ_B2, OFF_TGT_B2, OFF_CNT_B2: bidx = 2'd2;
            default:                            bidx = 2'd3;
        endcase
    end

    // Padded view of the addressed field and its byte-merged update
    always_comb begin
        unique case (off)
            OFF_REQ_LO, OFF_REQ_B2, OFF_REQ_B3:
                rfield = {{(FIELD_PAD-ADDR_W){1'b0}}, req_q};
            OFF_TGT_LO, OFF_TGT_B2, OFF_TGT_B3:
                rfield = {{(FIELD_PAD-ADDR_W){1'b0}}, tgt_q};
            default:
                rfield = {{(FIELD_PAD-CNT_W){1'b0}}, cnt_q};
        endcase
        rbyte  = rfield[bidx*BYTE_W +: BYTE_W];
        wfield = rfield;
        wfield[bidx*BYTE_W +: BYTE_W] = wdata;
    end

    // Store the merged value into the addressed field
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) begin
            req_q <= '0;
            tgt_q <= '0;
            cnt_q <= '0;
        end else if (we) begin
            unique case (off)
                OFF_REQ_LO, OFF_REQ_B2, OFF_REQ_B3: req_q <= wfield[ADDR_W-1:0];
                OFF_TGT_LO, OFF_TGT_B2, OFF_TGT_B3: tgt_q <= wfield[ADDR_W-1:0];
                default:                            cnt_q <= wfield[CNT_W-1:0];
            endcase
        end
    end

    p_b3_keeps_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !clr_all && off == OFF_REQ_B3) |=> (req_q[23:0] == $past(req_q[23:0])));
    p_b2_keeps_rest_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !clr_all && off == OFF_TGT_B2) |=> (tgt_q[15:0] == $past(tgt_q[15:0])));
    p_other_fields_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!we && !clr_all) |=> $stable(cnt_q) && $stable(req_q));
endmodule

// File: rtl/dma_regif_top.sv
// Top of the DMA programming front end: address decode, shared byte
// pointer, per-channel value registers, mask vector and completion interrupt.
// Assumes one bus access per cycle and NUM_CH no larger than 8.
module dma_regif_top
    import dma_regif_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 26,
    parameter int CNT_W  = 24,
    parameter int IO_AW  = $clog2(NUM_CH * CH_SLOTS + CH_SLOTS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [IO_AW-1:0]         io_addr,
    input  logic                     io_wr,
    input  logic                     io_rd,
    input  logic [BYTE_W-1:0]        io_wdata,
    output logic [BYTE_W-1:0]        io_rdata,
    input  logic                     tc_pulse_i,
    output logic [NUM_CH*ADDR_W-1:0] req_addr_o,
    output logic [NUM_CH*ADDR_W-1:0] tgt_addr_o,
    output logic [NUM_CH*CNT_W-1:0]  byte_cnt_o,
    output logic [NUM_CH-1:0]        ch_mask_o,
    output logic                     tc_irq_o
);
    logic [NUM_CH-1:0] chan_sel;
    reg_off_e          off;
    logic              shared_hit, mask_hit;
    logic              clr_ptr, clr_all, clr_mask, clr_tc, mask_we;
    logic              ptr;
    logic [BYTE_W-1:0] ch_rbyte [NUM_CH];

    dma_cmd_decode #(.NUM_CH(NUM_CH), .IO_AW(IO_AW)) u_dec (
        .io_addr(io_addr), .io_wr(io_wr), .chan_sel(chan_sel), .off(off),
        .shared_hit(shared_hit), .mask_hit(mask_hit), .clr_ptr(clr_ptr),
        .clr_all(clr_all), .clr_mask(clr_mask), .clr_tc(clr_tc), .mask_we(mask_we)
    );

    dma_byte_ptr u_ptr (
        .clk(clk), .rst_n(rst_n), .clr_all(clr_all), .clr_ptr(clr_ptr),
        .access(shared_hit && (io_wr || io_rd)), .ptr(ptr)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        dma_chan_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
            .clk(clk), .rst_n(rst_n), .clr_all(clr_all),
            .we(io_wr && chan_sel[c]), .off(off), .ptr(ptr), .wdata(io_wdata),
            .req_q(req_addr_o[c*ADDR_W +: ADDR_W]),
            .tgt_q(tgt_addr_o[c*ADDR_W +: ADDR_W]),
            .cnt_q(byte_cnt_o[c*CNT_W +: CNT_W]),
            .rbyte(ch_rbyte[c])
        );
    end

    // Mask vector: defaults to all disabled, loaded or cleared by command
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) ch_mask_o <= '1;
        else if (clr_mask)     ch_mask_o <= '0;
        else if (mask_we)      ch_mask_o <= io_wdata[NUM_CH-1:0];
    end

    // Completion interrupt: set by the datapath pulse, cleared by command
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) tc_irq_o <= 1'b0;
        else if (tc_pulse_i)   tc_irq_o <= 1'b1;
        else if (clr_tc)       tc_irq_o <= 1'b0;
    end

    // Read data multiplexer
    always_comb begin
        io_rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (chan_sel[c]) io_rdata = ch_rbyte[c];
        end
        if (mask_hit) io_rdata = {{(BYTE_W-NUM_CH){1'b0}}, ch_mask_o};
    end

    p_defaults_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (ch_mask_o == '1 && !tc_irq_o && req_addr_o == '0 && byte_cnt_o == '0));
    p_mask_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_mask |=> (ch_mask_o == '0));
    p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_irq_o && !clr_tc && !clr_all) |=> tc_irq_o);
    p_irq_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_tc && !tc_pulse_i) |=> !tc_irq_o);
    p_sel_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chan_sel));
endmodule

// File: tb/tb_dma_regif_top.sv
// Bench: behavioural reference model updated every clock and compared on
// every cycle against the read data and all outputs.
module tb_dma_regif_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  io_addr = '0;
    logic        io_wr = 1'b0, io_rd = 1'b0, tc_pulse_i = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic [103:0] req_addr_o, tgt_addr_o;
    logic [95:0]  byte_cnt_o;
    logic [3:0]   ch_mask_o;
    logic         tc_irq_o;

    int n_run = 0, n_fail = 0;
    bit finished = 1'b0;

    int unsigned m_req[4], m_tgt[4], m_cnt[4];
    bit          m_ptr;
    bit [3:0]    m_mask;
    bit          m_irq;

    always #4 clk = ~clk;

    dma_regif_top dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .tc_pulse_i(tc_pulse_i),
        .req_addr_o(req_addr_o), .tgt_addr_o(tgt_addr_o), .byte_cnt_o(byte_cnt_o),
        .ch_mask_o(ch_mask_o), .tc_irq_o(tc_irq_o)
    );

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int unsigned put_byte(int unsigned v, int idx, bit [7:0] d);
        int unsigned m = 32'hFF << (idx * 8);
        return (v & ~m) | (int'(d) << (idx * 8));
    endfunction

    function automatic bit [7:0] model_read(bit [5:0] a);
        int c = a / 8;
        int lo = m_ptr ? 8 : 0;
        if (a < 32) begin
            case (a % 8)
                0: return 8'(m_req[c] >> lo);
                1: return 8'(m_req[c] >> 16);
                2: return 8'(m_req[c] >> 24);
                3: return 8'(m_tgt[c] >> lo);
                4: return 8'(m_tgt[c] >> 16);
                5: return 8'(m_tgt[c] >> 24);
                6: return 8'(m_cnt[c] >> lo);
                default: return 8'(m_cnt[c] >> 16);
            endcase
        end
        if (a == 6'h24) return {4'b0, m_mask};
        return 8'h00;
    endfunction

    task automatic model_reset();
        for (int c = 0; c < 4; c++) begin m_req[c] = 0; m_tgt[c] = 0; m_cnt[c] = 0; end
        m_ptr = 0; m_mask = 4'hF; m_irq = 0;
    endtask

    task automatic model_step(bit [5:0] a, bit w, bit r, bit [7:0] d, bit tc);
        int c = a / 8;
        int sidx = m_ptr ? 1 : 0;
        bit shared = (a < 32) && ((a % 8) == 0 || (a % 8) == 3 || (a % 8) == 6);
        if (w && a == 6'h21) begin model_reset(); return; end
        if (w && a < 32) begin
            case (a % 8)
                0: m_req[c] = put_byte(m_req[c], sidx, d);
                1: m_req[c] = put_byte(m_req[c], 2, d);
                2: m_req[c] = put_byte(m_req[c], 3, d) & 32'h3FF_FFFF;
                3: m_tgt[c] = put_byte(m_tgt[c], sidx, d);
                4: m_tgt[c] = put_byte(m_tgt[c], 2, d);
                5: m_tgt[c] = put_byte(m_tgt[c], 3, d) & 32'h3FF_FFFF;
                6: m_cnt[c] = put_byte(m_cnt[c], sidx, d);
                default: m_cnt[c] = put_byte(m_cnt[c], 2, d);
            endcase
        end
        if (w && a == 6'h20) m_ptr = 0;
        else if (shared && (w || r)) m_ptr = ~m_ptr;
        if (w && a == 6'h22) m_mask = 0;
        else if (w && a == 6'h24) m_mask = d[3:0];
        if (tc) m_irq = 1;
        else if (w && a == 6'h23) m_irq = 0;
    endtask

    task automatic check_outputs(input string tag);
        for (int c = 0; c < 4; c++) begin
            check(tag, $sformatf("req ch%0d", c), longint'(req_addr_o[c*26 +: 26]), longint'(m_req[c]));
            check(tag, $sformatf("tgt ch%0d", c), longint'(tgt_addr_o[c*26 +: 26]), longint'(m_tgt[c]));
            check(tag, $sformatf("cnt ch%0d", c), longint'(byte_cnt_o[c*24 +: 24]), longint'(m_cnt[c]));
        end
        check(tag, "mask", longint'(ch_mask_o), longint'(m_mask));
        check(tag, "irq", longint'(tc_irq_o), longint'(m_irq));
    endtask

    // One bus cycle: drive, check read data mid-cycle, advance model, check outputs
    task automatic step(input bit [5:0] a, input bit w, input bit r, input bit [7:0] d,
                        input bit tc, input string tag);
        @(negedge clk);
        io_addr = a; io_wr = w; io_rd = r; io_wdata = d; tc_pulse_i = tc;
        #2;
        check(tag, $sformatf("rdata @%0h", a), longint'(io_rdata), longint'(model_read(a)));
        @(posedge clk);
        if (!rst_n) model_reset(); else model_step(a, w, r, d, tc);
        #1;
        check_outputs(tag);
    endtask

    task automatic idle(input string tag);
        step(6'h3F, 0, 0, 8'h00, 0, tag);
    endtask

    initial begin
        model_reset();
        step(6'h00, 1, 0, 8'hEE, 1, "R1");
        step(6'h00, 1, 0, 8'hEE, 1, "R1");
        rst_n = 1'b1;
        idle("R1");
        step(6'h00, 0, 0, 8'h00, 0, "R1");
        // R2 shared requester bytes, low then high
        step(6'h00, 1, 0, 8'h12, 0, "R2");
        step(6'h00, 1, 0, 8'h34, 0, "R2");
        step(6'h00, 0, 1, 8'h00, 0, "R2");
        step(6'h00, 0, 1, 8'h00, 0, "R2");
        // R3 dedicated bytes leave the selector at 1 after one shared write
        step(6'h03, 1, 0, 8'hAB, 0, "R3");
        step(6'h01, 1, 0, 8'h56, 0, "R3");
        step(6'h02, 1, 0, 8'hFF, 0, "R3");
        step(6'h02, 0, 1, 8'h00, 0, "R3");
        step(6'h03, 1, 0, 8'hCD, 0, "R3");
        step(6'h05, 1, 0, 8'hFE, 0, "R3");
        // R5 selector clear mid-sequence with nonzero data
        step(6'h06, 1, 0, 8'h77, 0, "R5");
        step(6'h20, 1, 0, 8'h5A, 0, "R5");
        step(6'h06, 1, 0, 8'h99, 0, "R5");
        step(6'h06, 0, 1, 8'h00, 0, "R5");
        // R11 fill every channel with distinct patterns
        for (int c = 0; c < 4; c++) begin
            for (int o = 0; o < 8; o++) begin
                step(6'(c * 8 + o), 1, 0, 8'(c * 37 + o * 11 + 5), 0, "R11");
                if (o == 0 || o == 3 || o == 6)
                    step(6'(c * 8 + o), 1, 0, 8'(c * 13 + o * 7 + 200), 0, "R11");
            end
        end
        for (int a = 0; a < 40; a++) step(6'(a), 0, 0, 8'h00, 0, "R4");
        step(6'h21, 0, 1, 8'h00, 0, "R4");
        step(6'h3C, 0, 1, 8'h00, 0, "R4");
        // R7 mask write and readback
        step(6'h24, 1, 0, 8'hA5, 0, "R7");
        step(6'h24, 0, 1, 8'h00, 0, "R7");
        // R8 clear all masks
        step(6'h22, 1, 0, 8'h00, 0, "R8");
        step(6'h24, 0, 1, 8'h00, 0, "R8");
        // R9 interrupt set and hold
        step(6'h3F, 0, 0, 8'h00, 1, "R9");
        idle("R9");
        idle("R9");
        // R10 clear, clear racing a pulse, then clear again
        step(6'h23, 1, 0, 8'h3C, 0, "R10");
        step(6'h3F, 0, 0, 8'h00, 1, "R10");
        step(6'h23, 1, 0, 8'h00, 1, "R10");
        idle("R10");
        step(6'h23, 1, 0, 8'hFF, 0, "R10");
        // R6 controller clear with a racing pulse, selector left at 1 first
        step(6'h24, 1, 0, 8'h03, 0, "R6");
        step(6'h00, 1, 0, 8'h11, 1, "R6");
        step(6'h21, 1, 0, 8'h81, 1, "R6");
        step(6'h00, 1, 0, 8'h42, 0, "R6");
        step(6'h00, 0, 1, 8'h00, 0, "R6");
        idle("R6");
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule